// File: doc/BRIEF.md
# Hypervisor Exception Entry Controller

This block performs the state update a 32-bit core needs when an exception is routed to its hypervisor privilege mode. The core presents a one-cycle request carrying an exception type code, the level it is running at, the faulting virtual address, a syndrome word, its current status word, the preferred return address and three routing bits from the secure configuration. On the next clock edge the block produces the entry PC, the new status word (hypervisor mode and the interrupt masks), a saved copy of the old status word and the return address. It also captures the fault address and syndrome registers as the exception type requires.

The vector offset is chosen by the exception type. Any entry from a level below the hypervisor level lands on the common entry at offset 0x14 when the type's own offset is smaller. The asynchronous-abort, IRQ and FIQ masks depend only on the routing bits. The vector base register is loaded through a plain write port and is always 32-byte aligned. A request carrying an unknown type code produces an error pulse and changes no state. A new request may follow on every cycle.

Top module: `hyp_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, every output is zero.
- R2: Type codes are 0 undefined instruction, 1 hypervisor call, 2 prefetch abort, 3 data abort, 4 supervisor call, 5 hypervisor trap, 6 IRQ, 7 FIQ, 8 breakpoint. From the hypervisor level (cur_el equal to 2) the offsets are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x14, 0x18 and 0x1C in that code order.
- R3: A breakpoint (code 8) behaves exactly like a prefetch abort: offset 0x0C from the hypervisor level, and its address goes to the instruction fault address register.
- R4: When cur_el is not 2, an offset below 0x14 is replaced by 0x14; offsets 0x14 and above are kept.
- R5: The cycle after an accepted request, entry_pulse is high for one cycle and target_pc equals the vector base plus the offset.
- R6: A prefetch abort or breakpoint copies fault_va into ifar_q; a data abort copies it into dfar_q. Other types leave both unchanged.
- R7: Every accepted type except IRQ and FIQ copies syndrome_in into hsr_q; IRQ and FIQ leave hsr_q unchanged.
- R8: In new_status, bit 8 (asynchronous abort mask) is set when route_ea is 0, bit 7 (IRQ mask) when route_irq is 0, and bit 6 (FIQ mask) when route_fiq is 0. When the routing bit is 1, the bit keeps its value from cur_status.
- R9: On entry new_status[4:0] becomes 0x1A and its other bits follow cur_status except as in R8. saved_status takes cur_status and ret_addr takes pref_ret unchanged (zero return offset).
- R10: Codes 9 to 15 produce a one-cycle err_pulse with no entry_pulse. No output register other than the pulses changes.
- R11: A write through vbar_we stores vbar_wdata with bits 4:0 cleared. A request in the same cycle uses the value held before the write.
- R12: Requests on consecutive cycles are each accepted, and each yields its own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_type | input | 4 | Exception type code |
| cur_el | input | 2 | Current exception level |
| cur_status | input | 32 | Current status word |
| pref_ret | input | 32 | Preferred return address |
| fault_va | input | 32 | Faulting virtual address |
| syndrome_in | input | 32 | Exception syndrome |
| route_ea | input | 1 | External-abort routing bit |
| route_irq | input | 1 | IRQ routing bit |
| route_fiq | input | 1 | FIQ routing bit |
| vbar_we | input | 1 | Vector base write enable |
| vbar_wdata | input | 32 | Vector base write data |
| entry_pulse | output | 1 | Mode-switch strobe, one cycle |
| err_pulse | output | 1 | Unsupported-type strobe, one cycle |
| target_pc | output | 32 | Entry PC |
| new_status | output | 32 | Status word after entry |
| saved_status | output | 32 | Saved status word |
| ret_addr | output | 32 | Saved return address |
| ifar_q | output | 32 | Instruction fault address register |
| dfar_q | output | 32 | Data fault address register |
| hsr_q | output | 32 | Syndrome register |
| vbar_q | output | 32 | Vector base register |

## Verification
Every result sits one register stage after its stimulus. The pulses, PC, status words, fault registers, syndrome and vector base are all valid in the cycle after the edge that samples the request or write. The bench drives inputs on the falling edge, holds them through one rising edge, and reads the outputs on the next falling edge. Back-to-back requests are checked by reading the first result while the second request is being driven, and the second result one cycle later.

// File: rtl/hyp_entry_pkg.sv
package hyp_entry_pkg;
    localparam int TYPE_W   = 4;
    localparam int MODE_W   = 5;
    localparam logic [MODE_W-1:0] HYP_MODE = 5'h1A;
    localparam int BIT_F    = 6;   // FIQ mask; IRQ and abort masks sit just above
    localparam int NUM_MASK = 3;

    typedef enum logic [TYPE_W-1:0] {
        EXC_UNDEF = 4'd0,
        EXC_HVC   = 4'd1,
        EXC_PABT  = 4'd2,
        EXC_DABT  = 4'd3,
        EXC_SVC   = 4'd4,
        EXC_TRAP  = 4'd5,
        EXC_IRQ   = 4'd6,
        EXC_FIQ   = 4'd7,
        EXC_BKPT  = 4'd8
    } exc_type_e;
endpackage

// File: rtl/hyp_vec_sel.sv
module hyp_vec_sel
    import hyp_entry_pkg::*;
#(
    parameter int OFF_W  = 5,
    parameter int EL_W   = 2,
    parameter int HYP_EL = 2
) (
    input  logic [TYPE_W-1:0] exc_type,
    input  logic [EL_W-1:0]   cur_el,
    output logic [OFF_W-1:0]  offset,
    output logic              known,
    output logic              cap_ifar,
    output logic              cap_dfar,
    output logic              cap_syn
);
    localparam logic [OFF_W-1:0] COMMON_OFF = OFF_W'(5'h14);

    logic [OFF_W-1:0] raw_off;

    always_comb begin
        raw_off  = '0;
        known    = 1'b1;
        cap_ifar = 1'b0;
        cap_dfar = 1'b0;
        cap_syn  = 1'b1;
        case (exc_type)
            EXC_UNDEF: raw_off = OFF_W'(5'h04);
            EXC_HVC:   raw_off = OFF_W'(5'h08);
            EXC_PABT,
            EXC_BKPT: begin
                raw_off  = OFF_W'(5'h0C);
                cap_ifar = 1'b1;
            end
            EXC_DABT: begin
                raw_off  = OFF_W'(5'h10);
                cap_dfar = 1'b1;
            end
            EXC_SVC,
            EXC_TRAP:  raw_off = COMMON_OFF;
            EXC_IRQ: begin
                raw_off = OFF_W'(5'h18);
                cap_syn = 1'b0;
            end
            EXC_FIQ: begin
                raw_off = OFF_W'(5'h1C);
                cap_syn = 1'b0;
            end
            default: begin
                known   = 1'b0;
                cap_syn = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (cur_el != EL_W'(HYP_EL) && raw_off < COMMON_OFF)
            offset = COMMON_OFF;
        else
            offset = raw_off;
    end
endmodule

// File: rtl/hyp_mask_gen.sv
module hyp_mask_gen
    import hyp_entry_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur_status,
    input  logic          route_ea,
    input  logic          route_irq,
    input  logic          route_fiq,
    output logic [DW-1:0] next_status
);
    logic [NUM_MASK-1:0] route_vec;
    logic [NUM_MASK-1:0] mask_bits;

    assign route_vec = {route_ea, route_irq, route_fiq};

    for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
        assign mask_bits[g] = route_vec[g] ? cur_status[BIT_F+g] : 1'b1;
    end

    always_comb begin
        next_status = cur_status;
        next_status[BIT_F +: NUM_MASK] = mask_bits;
        next_status[MODE_W-1:0] = HYP_MODE;
    end
endmodule

// File: rtl/hyp_entry_ctrl.sv
module hyp_entry_ctrl
    import hyp_entry_pkg::*;
#(
    parameter int DW      = 32,
    parameter int EL_W    = 2,
    parameter int HYP_EL  = 2,
    parameter int ALIGN_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [TYPE_W-1:0]    req_type,
    input  logic [EL_W-1:0]      cur_el,
    input  logic [DW-1:0]        cur_status,
    input  logic [DW-1:0]        pref_ret,
    input  logic [DW-1:0]        fault_va,
    input  logic [DW-1:0]        syndrome_in,
    input  logic                 route_ea,
    input  logic                 route_irq,
    input  logic                 route_fiq,
    input  logic                 vbar_we,
    input  logic [DW-1:0]        vbar_wdata,
    output logic                 entry_pulse,
    output logic                 err_pulse,
    output logic [DW-1:0]        target_pc,
    output logic [DW-1:0]        new_status,
    output logic [DW-1:0]        saved_status,
    output logic [DW-1:0]        ret_addr,
    output logic [DW-1:0]        ifar_q,
    output logic [DW-1:0]        dfar_q,
    output logic [DW-1:0]        hsr_q,
    output logic [DW-1:0]        vbar_q
);
    localparam int OFF_W = ALIGN_W;

    typedef struct packed {
        logic          entry;
        logic          err;
        logic [DW-1:0] pc;
        logic [DW-1:0] status;
        logic [DW-1:0] saved;
        logic [DW-1:0] elr;
        logic [DW-1:0] ifar;
        logic [DW-1:0] dfar;
        logic [DW-1:0] hsr;
        logic [DW-1:0] vbar;
    } state_t;

    state_t st_d, st_q;

    logic [OFF_W-1:0] vec_off;
    logic             type_known;
    logic             cap_ifar, cap_dfar, cap_syn;
    logic [DW-1:0]    status_entry;

    hyp_vec_sel #(.OFF_W(OFF_W), .EL_W(EL_W), .HYP_EL(HYP_EL)) u_vec (
        .exc_type (req_type),
        .cur_el   (cur_el),
        .offset   (vec_off),
        .known    (type_known),
        .cap_ifar (cap_ifar),
        .cap_dfar (cap_dfar),
        .cap_syn  (cap_syn)
    );

    hyp_mask_gen #(.DW(DW)) u_mask (
        .cur_status  (cur_status),
        .route_ea    (route_ea),
        .route_irq   (route_irq),
        .route_fiq   (route_fiq),
        .next_status (status_entry)
    );

    always_comb begin
        st_d       = st_q;
        st_d.entry = 1'b0;
        st_d.err   = 1'b0;
        if (req_valid) begin
            if (type_known) begin
                st_d.entry  = 1'b1;
                st_d.pc     = st_q.vbar + DW'(vec_off);
                st_d.status = status_entry;
                st_d.saved  = cur_status;
                st_d.elr    = pref_ret;
                if (cap_ifar) st_d.ifar = fault_va;
                if (cap_dfar) st_d.dfar = fault_va;
                if (cap_syn)  st_d.hsr  = syndrome_in;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (vbar_we)
            st_d.vbar = {vbar_wdata[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entry_pulse  = st_q.entry;
    assign err_pulse    = st_q.err;
    assign target_pc    = st_q.pc;
    assign new_status   = st_q.status;
    assign saved_status = st_q.saved;
    assign ret_addr     = st_q.elr;
    assign ifar_q       = st_q.ifar;
    assign dfar_q       = st_q.dfar;
    assign hsr_q        = st_q.hsr;
    assign vbar_q       = st_q.vbar;

    // Entry and error strobes never coincide.
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry_pulse && err_pulse));

    // Rejected request leaves the architectural registers untouched.
    assert_err_no_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($stable(ifar_q) && $stable(dfar_q) && $stable(hsr_q)
                       && $stable(saved_status) && $stable(target_pc)));

    // Entry PC lies in the block based on the vector base seen at request time.
    assert_pc_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> target_pc[DW-1:ALIGN_W] == $past(vbar_q[DW-1:ALIGN_W]));

    // Entries from lower levels never land below the common offset.
    assert_low_level_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && $past(cur_el) != EL_W'(HYP_EL))
            |-> target_pc[ALIGN_W-1:0] >= ALIGN_W'(5'h14));

    // Mode field reports hypervisor after every entry.
    assert_mode_hyp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> new_status[MODE_W-1:0] == HYP_MODE);

    // Interrupts do not touch the syndrome register.
    assert_irq_keeps_syn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && ($past(req_type) == EXC_IRQ || $past(req_type) == EXC_FIQ))
            |-> $stable(hsr_q));

    // Vector base stays 32-byte aligned.
    assert_vbar_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vbar_we) |-> vbar_q[ALIGN_W-1:0] == '0);
endmodule

// File: tb/tb_hyp_entry_ctrl.sv
module tb_hyp_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_type;
    logic [1:0]  cur_el;
    logic [31:0] cur_status, pref_ret, fault_va, syndrome_in;
    logic        route_ea, route_irq, route_fiq;
    logic        vbar_we;
    logic [31:0] vbar_wdata;
    logic        entry_pulse, err_pulse;
    logic [31:0] target_pc, new_status, saved_status, ret_addr;
    logic [31:0] ifar_q, dfar_q, hsr_q, vbar_q;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyp_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .cur_el(cur_el), .cur_status(cur_status), .pref_ret(pref_ret),
        .fault_va(fault_va), .syndrome_in(syndrome_in), .route_ea(route_ea),
        .route_irq(route_irq), .route_fiq(route_fiq), .vbar_we(vbar_we),
        .vbar_wdata(vbar_wdata), .entry_pulse(entry_pulse), .err_pulse(err_pulse),
        .target_pc(target_pc), .new_status(new_status), .saved_status(saved_status),
        .ret_addr(ret_addr), .ifar_q(ifar_q), .dfar_q(dfar_q), .hsr_q(hsr_q),
        .vbar_q(vbar_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_off(input logic [3:0] t, input logic [1:0] el);
        logic [31:0] o;
        case (t)
            4'd0: o = 32'h04; 4'd1: o = 32'h08; 4'd2: o = 32'h0C; 4'd3: o = 32'h10;
            4'd4: o = 32'h14; 4'd5: o = 32'h14; 4'd6: o = 32'h18; 4'd7: o = 32'h1C;
            default: o = 32'h0C;
        endcase
        if (el != 2'd2 && o < 32'h14) o = 32'h14;
        return o;
    endfunction

    function automatic logic [31:0] exp_stat(input logic [31:0] s, input logic ea,
                                             input logic irq, input logic fiq);
        logic [31:0] r = s;
        if (!ea)  r[8] = 1'b1;
        if (!irq) r[7] = 1'b1;
        if (!fiq) r[6] = 1'b1;
        r[4:0] = 5'h1A;
        return r;
    endfunction

    task automatic drive(input logic [3:0] t, input logic [1:0] el, input logic [31:0] st,
                         input logic [31:0] va, input logic [31:0] syn, input logic [2:0] rt);
        req_valid = 1'b1; req_type = t; cur_el = el; cur_status = st;
        pref_ret = va ^ 32'h1111_0000; fault_va = va; syndrome_in = syn;
        {route_ea, route_irq, route_fiq} = rt;
    endtask

    task automatic idle();
        req_valid = 1'b0; vbar_we = 1'b0;
    endtask

    task automatic write_vbar(input logic [31:0] v);
        @(negedge clk); vbar_we = 1'b1; vbar_wdata = v;
        @(negedge clk); vbar_we = 1'b0;
        chk("R11 vbar aligned", vbar_q, {v[31:5], 5'b0});
    endtask

    // One request, outputs read on the following falling edge.
    task automatic one_req(input string tag, input logic [3:0] t, input logic [1:0] el,
                           input logic [31:0] st, input logic [31:0] va,
                           input logic [31:0] syn, input logic [2:0] rt);
        logic [31:0] ifar0 = ifar_q, dfar0 = dfar_q, hsr0 = hsr_q, vb = vbar_q;
        @(negedge clk); drive(t, el, st, va, syn, rt);
        @(negedge clk); idle();
        chk({tag, " R5 entry pulse"}, {31'b0, entry_pulse}, 32'd1);
        chk({tag, " R2/R4 pc"}, target_pc, vb + exp_off(t, el));
        chk({tag, " R8 status"}, new_status, exp_stat(st, rt[2], rt[1], rt[0]));
        chk({tag, " R9 saved"}, saved_status, st);
        chk({tag, " R9 ret"}, ret_addr, va ^ 32'h1111_0000);
        chk({tag, " R6 ifar"}, ifar_q, (t == 4'd2 || t == 4'd8) ? va : ifar0);
        chk({tag, " R6 dfar"}, dfar_q, (t == 4'd3) ? va : dfar0);
        chk({tag, " R7 hsr"}, hsr_q, (t == 4'd6 || t == 4'd7) ? hsr0 : syn);
        @(negedge clk);
        chk({tag, " R5 pulse one cycle"}, {31'b0, entry_pulse}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); req_type = '0; cur_el = '0; cur_status = '0;
        pref_ret = '0; fault_va = '0; syndrome_in = '0; vbar_wdata = '0;
        route_ea = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 entry", {31'b0, entry_pulse}, 0);
        chk("R1 err", {31'b0, err_pulse}, 0);
        chk("R1 pc", target_pc, 0);
        chk("R1 status", new_status, 0);
        chk("R1 hsr", hsr_q, 0);
        chk("R1 vbar", vbar_q, 0);
    endtask

    task automatic t_hyp_table();
        for (int t = 0; t < 8; t++)
            one_req("R2 hyp level", 4'(t), 2'd2, 32'h0000_0013, 32'hA000_0000 + 32'(t),
                    32'h5500_0000 + 32'(t), 3'b111);
    endtask

    task automatic t_bkpt();
        one_req("R3 bkpt hyp", 4'd8, 2'd2, 32'h0000_0010, 32'hBEEF_0040, 32'h3C00_0001, 3'b000);
        one_req("R3 bkpt low", 4'd8, 2'd0, 32'h0000_0010, 32'hBEEF_0080, 32'h3C00_0002, 3'b101);
    endtask

    task automatic t_low_level();
        for (int t = 0; t < 8; t++)
            one_req("R4 low level", 4'(t), 2'd1, 32'hF000_01D0, 32'hC000_0100 + 32'(t),
                    32'h6600_0000 + 32'(t), 3'b010);
    endtask

    task automatic t_masks();
        for (int r = 0; r < 8; r++) begin
            one_req("R8 masks clear", 4'd4, 2'd2, 32'h0000_0010, 32'h0, 32'h1, 3'(r));
            one_req("R8 masks set", 4'd4, 2'd2, 32'h8000_01DF, 32'h0, 32'h2, 3'(r));
        end
    endtask

    task automatic t_bad_type();
        for (int t = 9; t < 16; t++) begin
            logic [31:0] pc0 = target_pc, st0 = new_status, sv0 = saved_status;
            logic [31:0] if0 = ifar_q, df0 = dfar_q, hs0 = hsr_q;
            @(negedge clk); drive(4'(t), 2'd2, 32'h1234_5678, 32'hDEAD_0000, 32'h7777_7777, 3'b000);
            @(negedge clk); idle();
            chk("R10 err pulse", {31'b0, err_pulse}, 1);
            chk("R10 no entry", {31'b0, entry_pulse}, 0);
            chk("R10 pc held", target_pc, pc0);
            chk("R10 status held", new_status, st0);
            chk("R10 saved held", saved_status, sv0);
            chk("R10 ifar held", ifar_q, if0);
            chk("R10 dfar held", dfar_q, df0);
            chk("R10 hsr held", hsr_q, hs0);
        end
    endtask

    task automatic t_vbar_same_cycle();
        logic [31:0] old = vbar_q;
        @(negedge clk);
        drive(4'd6, 2'd2, 32'h10, 32'h0, 32'h0, 3'b111);
        vbar_we = 1'b1; vbar_wdata = 32'h7FFF_FFFF;
        @(negedge clk); idle();
        chk("R11 old base used", target_pc, old + 32'h18);
        chk("R11 new base stored", vbar_q, 32'h7FFF_FFE0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] vb = vbar_q;
        @(negedge clk); drive(4'd3, 2'd2, 32'h10, 32'hD000_0004, 32'h9000_0001, 3'b111);
        @(negedge clk); drive(4'd7, 2'd1, 32'h10, 32'hE000_0008, 32'h9000_0002, 3'b111);
        chk("R12 first pulse", {31'b0, entry_pulse}, 1);
        chk("R12 first pc", target_pc, vb + 32'h10);
        chk("R12 first dfar", dfar_q, 32'hD000_0004);
        @(negedge clk); idle();
        chk("R12 second pulse", {31'b0, entry_pulse}, 1);
        chk("R12 second pc", target_pc, vb + 32'h1C);
        chk("R12 second hsr kept", hsr_q, 32'h9000_0001);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        write_vbar(32'h8000_001F);
        t_hyp_table();
        t_bkpt();
        write_vbar(32'h4000_1234);
        t_low_level();
        t_masks();
        t_bad_type();
        t_vbar_same_cycle();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule